// File: doc/BRIEF.md
# GPIO Edge Capture and Interrupt Merge

This block watches the synchronized levels of a set of general-purpose pins, grouped into banks of equal width. The default is four banks of 32 pins. When a pin is configured as an input, the block compares each new sample with the sample from the previous cycle. A qualifying rising or falling edge latches a bit in that bank's status word. Each status bit stays set until software writes a one to it. Writing a zero leaves the bit as it was. The register decode sits outside the block. It presents each clear as a strobe, a bank index and a data word.

The status words drive three registered interrupt lines:
- one line follows pin 0 of bank 0;
- one line follows pin 1 of bank 0;
- one shared line covers every other status bit in every bank.

A separate wake request is raised while the processor reports that it is halted. It fires when any input pin that appears in a fixed per-bank wake mask changes level. The edge-enable settings play no part in the wake request. Surrounding logic uses the status words for readback, feeds the interrupt lines to the interrupt controller, and uses the wake pulse to restart a sleeping core.

Top module: `gpio_edge_irq`

## Requirements
- R1: A status bit is set when the pin's rising-enable bit is 1, its direction bit is 0, and its level goes from 0 in the previous sampled cycle to 1 in the current sampled cycle. The status word updates on the clock edge that samples the new level.
- R2: A status bit is set when the pin's falling-enable bit is 1, its direction bit is 0, and its level goes from 1 to 0. If the falling-enable bit is 0, a falling edge sets nothing.
- R3: A pin whose direction bit is 1 (output) never sets its status bit, whatever its level changes and enable bits are.
- R4: Status bits are sticky. A clear strobe with bank index k clears exactly the bits of bank k where the clear data is 1. It leaves every other bit, and every other bank, unchanged.
- R5: When a new edge and a clear hit the same status bit in the same cycle, the bit remains set.
- R6: `irq_pin0` equals bank-0 status bit 0, and `irq_pin1` equals bank-0 status bit 1. Each is delayed by one clock.
- R7: `irq_shared` is the OR of bank-0 status bits 2 to 31 and all status bits of the other banks, delayed by one clock.
- R8: While `halted` is 1, a level change on an input pin whose bit is set in the wake mask produces `wake_req` high for one cycle. The pulse appears on the edge that samples the change, whatever the edge-enable settings are. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3.
- R9: No wake request is produced in any of these cases:
  - `halted` is 0;
  - the changing pin is not in the wake mask;
  - the changing pin is an output.
- R10: Synchronous reset clears all status bits and outputs. The first sample after reset only loads the previous-level register and produces neither an edge nor a wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_BANKS*BANK_W | Synchronized pin levels, bank b at bits b*BANK_W upward |
| pin_dir | input | NUM_BANKS*BANK_W | Direction per pin, 1 = output |
| rise_en | input | NUM_BANKS*BANK_W | Rising-edge capture enable per pin |
| fall_en | input | NUM_BANKS*BANK_W | Falling-edge capture enable per pin |
| clr_we | input | 1 | Status clear strobe |
| clr_bank | input | $clog2(NUM_BANKS) | Bank selected by the clear |
| clr_data | input | BANK_W | Ones mark status bits to clear |
| halted | input | 1 | Processor halted or sleeping |
| status | output | NUM_BANKS*BANK_W | Sticky edge status for readback |
| irq_pin0 | output | 1 | Interrupt for bank-0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank-0 pin 1 |
| irq_shared | output | 1 | Interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The assertions assume that `pin_level` is already synchronized to `clk`. They also assume that direction and enable inputs hold their values for a whole cycle, so that a change between two samples is a real edge. They assume `clr_bank` is always below the bank count. The stimulus drives every input only on the falling clock edge and keeps the bank index in range. A reference model in the bench recomputes status, interrupts and wake on every rising edge. Its results are compared at each falling edge, through directed sequences and a long stretch of random pin, direction, enable, clear and halt traffic.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int DEF_BANKS  = 4;
  localparam int DEF_BANK_W = 32;
  // wake-capable pins, bank 0 in the low word
  localparam logic [DEF_BANKS*DEF_BANK_W-1:0] DEF_WAKE_MASK =
    {32'h0012007F, 32'hEC080000, 32'h002001FC, 32'h8003FE1B};
endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int          BANK_W    = 32,
  parameter logic [31:0] WAKE_BITS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_ok,
  input  logic [BANK_W-1:0] level,
  input  logic [BANK_W-1:0] dir,
  input  logic [BANK_W-1:0] rise_en,
  input  logic [BANK_W-1:0] fall_en,
  input  logic              clr_hit,
  input  logic [BANK_W-1:0] clr_data,
  input  logic              halted,
  output logic [BANK_W-1:0] status,
  output logic              wake_hit
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] status_q;
  logic [BANK_W-1:0] rose, fell, set_bits, clr_mask, wake_vec;

  always_comb begin
    rose     = ~prev_q & level;
    fell     = prev_q & ~level;
    set_bits = sample_ok ? (((rose & rise_en) | (fell & fall_en)) & ~dir) : '0;
    clr_mask = clr_hit ? clr_data : '0;
    wake_vec = (prev_q ^ level) & ~dir & WAKE_BITS[BANK_W-1:0];
    wake_hit = halted & sample_ok & (|wake_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= (status_q & ~clr_mask) | set_bits;
    end
  end

  assign status = status_q;

  // R4: a bit only falls where a clear addressed it
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    ((($past(status_q) & ~status_q) & ~$past(clr_mask)) == '0));
  // R3: output pins never raise a status bit
  a_r3_outputs_ignored: assert property (@(posedge clk) disable iff (rst)
    (((status_q & ~$past(status_q)) & $past(dir)) == '0));
  // R1/R2: a bit only rises where the sampled level changed
  a_r1_needs_change: assert property (@(posedge clk) disable iff (rst)
    (((status_q & ~$past(status_q)) & ~($past(level) ^ $past(prev_q))) == '0));
  // R5: an edge is never lost to a concurrent clear
  a_r5_edge_wins: assert property (@(posedge clk) disable iff (rst)
    ((($past(set_bits) & ~status_q)) == '0));
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] status,
  input  logic [NUM_BANKS-1:0]        wake_hits,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared,
  output logic                        wake_req
);
  localparam int TOT = NUM_BANKS * BANK_W;
  localparam logic [TOT-1:0] SHARED_MASK = ~(TOT'(3));

  logic any_other;
  assign any_other = |(status & SHARED_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin0   <= 1'b0;
      irq_pin1   <= 1'b0;
      irq_shared <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      irq_pin0   <= status[0];
      irq_pin1   <= status[1];
      irq_shared <= any_other;
      wake_req   <= |wake_hits;
    end
  end

  // R6: dedicated lines follow their status bits one clock later
  a_r6_pin0_follows: assert property (@(posedge clk) disable iff (rst)
    ($past(status[0]) |-> irq_pin0));
  a_r6_pin1_follows: assert property (@(posedge clk) disable iff (rst)
    ($past(status[1]) |-> irq_pin1));
  // R7: shared line needs some other status bit
  a_r7_shared_source: assert property (@(posedge clk) disable iff (rst)
    (irq_shared |-> $past(any_other)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS = DEF_BANKS,
  parameter int BANK_W    = DEF_BANK_W,
  parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MASK = DEF_WAKE_MASK,
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int TOT    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TOT-1:0]    pin_level,
  input  logic [TOT-1:0]    pin_dir,
  input  logic [TOT-1:0]    rise_en,
  input  logic [TOT-1:0]    fall_en,
  input  logic              clr_we,
  input  logic [BIDX_W-1:0] clr_bank,
  input  logic [BANK_W-1:0] clr_data,
  input  logic              halted,
  output logic [TOT-1:0]    status,
  output logic              irq_pin0,
  output logic              irq_pin1,
  output logic              irq_shared,
  output logic              wake_req
);
  logic                 sample_ok_q;
  logic [NUM_BANKS-1:0] wake_hits;

  always_ff @(posedge clk) begin
    if (rst) sample_ok_q <= 1'b0;
    else     sample_ok_q <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic clr_hit;
    assign clr_hit = clr_we && (clr_bank == BIDX_W'(b));
    gpio_edge_bank #(
      .BANK_W   (BANK_W),
      .WAKE_BITS(32'(WAKE_MASK[b*BANK_W +: BANK_W]))
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .sample_ok(sample_ok_q),
      .level    (pin_level[b*BANK_W +: BANK_W]),
      .dir      (pin_dir[b*BANK_W +: BANK_W]),
      .rise_en  (rise_en[b*BANK_W +: BANK_W]),
      .fall_en  (fall_en[b*BANK_W +: BANK_W]),
      .clr_hit  (clr_hit),
      .clr_data (clr_data),
      .halted   (halted),
      .status   (status[b*BANK_W +: BANK_W]),
      .wake_hit (wake_hits[b])
    );
  end

  gpio_irq_merge #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_merge (
    .clk       (clk),
    .rst       (rst),
    .status    (status),
    .wake_hits (wake_hits),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_shared(irq_shared),
    .wake_req  (wake_req)
  );

  // R10: the first sample after reset changes nothing
  a_r10_first_sample_quiet: assert property (@(posedge clk) disable iff (rst)
    (!sample_ok_q |=> ($stable(status) && !wake_req)));
  // R9: wake only while halted
  a_r9_wake_needs_halt: assert property (@(posedge clk) disable iff (rst)
    (wake_req |-> $past(halted)));
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] pin_level = '1, pin_dir = '0, rise_en = '0, fall_en = '0;
  logic         clr_we = 1'b0;
  logic [1:0]   clr_bank = '0;
  logic [31:0]  clr_data = '0;
  logic         halted = 1'b0;
  logic [127:0] status;
  logic         irq_pin0, irq_pin1, irq_shared, wake_req;

  always #5 clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst(rst), .pin_level(pin_level), .pin_dir(pin_dir),
    .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we),
    .clr_bank(clr_bank), .clr_data(clr_data), .halted(halted),
    .status(status), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_shared(irq_shared), .wake_req(wake_req)
  );

  int    checks = 0, errors = 0, cycles = 0;
  string phase  = "R10";

  // behavioural reference
  logic [31:0] m_prev [4];
  logic [31:0] m_stat [4];
  logic [31:0] wmask  [4] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};
  bit m_valid, m_i0, m_i1, m_ix, m_wake;

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 4; b++) begin m_prev[b] = 0; m_stat[b] = 0; end
      m_valid = 0; m_i0 = 0; m_i1 = 0; m_ix = 0; m_wake = 0;
    end else begin
      m_i0 = m_stat[0][0];
      m_i1 = m_stat[0][1];
      m_ix = (m_stat[0] >> 2) != 0 || m_stat[1] != 0 || m_stat[2] != 0 || m_stat[3] != 0;
      m_wake = 0;
      for (int b = 0; b < 4; b++) begin
        for (int i = 0; i < 32; i++) begin
          bit now, was, inp;
          now = pin_level[b*32+i]; was = m_prev[b][i]; inp = !pin_dir[b*32+i];
          if (m_valid && halted && inp && wmask[b][i] && now != was) m_wake = 1;
          if (clr_we && clr_bank == b && clr_data[i]) m_stat[b][i] = 0;
          if (m_valid && inp && !was && now && rise_en[b*32+i]) m_stat[b][i] = 1;
          if (m_valid && inp && was && !now && fall_en[b*32+i]) m_stat[b][i] = 1;
          m_prev[b][i] = now;
        end
      end
      m_valid = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks += 2;
      if (status !== {m_stat[3], m_stat[2], m_stat[1], m_stat[0]}) begin
        errors++;
        $display("FAIL %s status act=%h exp=%h", phase, status,
                 {m_stat[3], m_stat[2], m_stat[1], m_stat[0]});
      end
      if ({irq_pin0, irq_pin1, irq_shared, wake_req} !== {m_i0, m_i1, m_ix, m_wake}) begin
        errors++;
        $display("FAIL %s irq/wake act=%b exp=%b", phase,
                 {irq_pin0, irq_pin1, irq_shared, wake_req}, {m_i0, m_i1, m_ix, m_wake});
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic expect_eq(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R10: pins high at release give no edge, everything cleared
    expect_eq("R10", status, '0);
    expect_eq("R10", {irq_pin0, irq_pin1, irq_shared, wake_req}, '0);
    rise_en = '1; pin_level = '0;
    tick();
    // R2: falling with falling-enable off sets nothing
    phase = "R2";
    expect_eq("R2", status, '0);
    phase = "R1";
    pin_level[1:0] = 2'b11;
    tick();
    expect_eq("R1", status[31:0], 32'h3);
    tick();
    phase = "R6";
    expect_eq("R6", {irq_pin0, irq_pin1, irq_shared}, 3'b110);
    phase = "R4";
    clr_we = 1; clr_bank = 0; clr_data = 32'h1;
    tick();
    clr_we = 0;
    expect_eq("R4", status[31:0], 32'h2);
    tick();
    expect_eq("R6", {irq_pin0, irq_pin1}, 2'b01);
    phase = "R3";
    pin_dir[63:32] = 32'h0000FFFF; pin_level[63:32] = '1;
    tick();
    expect_eq("R3", status[63:32], 32'hFFFF0000);
    tick();
    phase = "R7";
    expect_eq("R7", irq_shared, 1);
    phase = "R2";
    rise_en = '0; fall_en = '1; pin_level[95:64] = '1;
    tick();
    expect_eq("R2", status[95:64], '0);
    pin_level[95:64] = '0;
    tick();
    expect_eq("R2", status[95:64], 32'hFFFFFFFF);
    phase = "R5";
    pin_level[127:96] = '1;
    tick();
    pin_level[127:96] = '0; clr_we = 1; clr_bank = 3; clr_data = '1;
    tick();
    expect_eq("R5", status[127:96], 32'hFFFFFFFF);
    phase = "R4";
    tick();
    expect_eq("R4", status[127:96], '0);
    clr_bank = 2; clr_data = '0;
    tick();
    clr_we = 0;
    expect_eq("R4", status[95:64], 32'hFFFFFFFF);
    phase = "R8";
    fall_en = '0; pin_dir = '0; halted = 1; pin_level[0] = ~pin_level[0];
    tick();
    expect_eq("R8", wake_req, 1);
    tick();
    expect_eq("R8", wake_req, 0);
    phase = "R9";
    pin_level[2] = ~pin_level[2];
    tick();
    expect_eq("R9", wake_req, 0);
    halted = 0; pin_level[0] = ~pin_level[0];
    tick();
    expect_eq("R9", wake_req, 0);
    halted = 1; pin_dir[0] = 1; pin_level[0] = ~pin_level[0];
    tick();
    expect_eq("R9", wake_req, 0);
    phase = "R1/R2/R4/R5/R7/R8";
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 4; b++) begin
        pin_level[b*32 +: 32] ^= $urandom & $urandom;
        if (n % 50 == 0) begin
          pin_dir[b*32 +: 32] = $urandom & $urandom;
          rise_en[b*32 +: 32] = $urandom;
          fall_en[b*32 +: 32] = $urandom;
        end
      end
      clr_we = ($urandom % 3) == 0;
      clr_bank = 2'($urandom);
      clr_data = $urandom;
      halted = ($urandom % 2) == 0;
      tick();
    end
    clr_we = 0;
    tick();
    finish_run();
  end
endmodule